// File: doc/BRIEF.md
# Interleaved Multilevel Subband Line Sequencer

This block is the control sequencer for a hierarchical 2-D subband reconstruction datapath. The datapath rebuilds an image from four levels of luminance subbands and three levels for each chrominance component. The sequencer decides, on every clock, which line job is active: colour component, decomposition level, band type and sample position. It also drives the addresses for the per-level line-delay store and for the intermediate-result store that feeds the next level up.

Levels are not finished one after another. The sequencer walks a fixed 15-entry interleaved level order, so a lower level produces a new pair of lines only after the level above it has consumed both lines of the previous pair. Because of this, each level needs only two lines of storage. Chrominance line jobs are slotted in right after every luminance job below the top level, so the three components stay in step. One extra wrap cycle closes every line. A stall input freezes the whole sequencer. A skip input shortens a sample position to its two low-vertical bands. A short tag pipeline carries the job descriptor alongside the datapath.

Top module: `subband_seq`

## Requirements
- R1: While rst_ni is low, and in the first cycle after it is released, valid_o is 0 and tag_o is 0. The first job is component Y (0) at level 0, position 0, band LL, with wrap_o low.
- R2: Luminance line jobs follow the repeating level order 0,1,2,3,3,2,3,3,1,2,3,3,2,3,3. Level 0 is the coarsest level and level 3 the finest.
- R3: Each luminance job at a level below 3 is followed at once by a U job (component 1) and then a V job (component 2) at the same level. Chrominance never runs at level 3.
- R4: In normal operation the band code steps LL=0, LH=1, HL=2, HH=3 at each position.
- R5: skip_i is sampled in the LL cycle of a position. If it was high, the position ends after LH and the next cycle is LL of the next position (or the wrap cycle).
- R6: A line at level L has width_i >> (4-L) positions, and pos_o counts from 0 to that value minus 1. width_i is a multiple of 16 between 16 and 256 and is held constant between resets.
- R7: After the last position of a line comes exactly one wrap cycle, with wrap_o=1, pos_o=0 and band LL. In that cycle no memory enable is asserted. The next job begins in the following active cycle.
- R8: While stall_i is high, valid_o is 0, all memory enables are 0, and no state changes.
- R9: im_rd_en_o is high in every active non-wrap LL cycle at levels 1 to 3, with im_rd_addr_o = {comp, level-1, line, pos}. The line bit is 0 on the first job of a given component and level after reset and alternates on each later job.
- R10: im_wr_en_o is high in the last band cycle of each position (HH, or LH when skipped) for levels below the top level (3 for Y, 2 for U and V), with im_wr_addr_o = {comp, level, pos}.
- R11: ld_en_o is high in every active non-wrap cycle, with ld_addr_o = {comp, level, pos}. The same word is read and then rewritten.
- R12: tag_o = {valid, wrap, comp, level, band} of the cycle PIPE_DEPTH active cycles earlier. The pipeline shifts only in active cycles and holds while stalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| stall_i | input | 1 | Freeze all sequencer state |
| skip_i | input | 1 | Skip high-vertical bands for the position starting now |
| width_i | input | 9 | Top-level luminance line width in pixels |
| valid_o | output | 1 | Active cycle |
| comp_o | output | 2 | Component: Y=0, U=1, V=2 |
| level_o | output | 2 | Decomposition level of the current job |
| band_o | output | 2 | Band code LL=0, LH=1, HL=2, HH=3 |
| pos_o | output | 7 | Sample position within the line |
| wrap_o | output | 1 | Line-end wrap cycle |
| ld_en_o | output | 1 | Line-delay access enable |
| ld_addr_o | output | 11 | Line-delay word address |
| im_rd_en_o | output | 1 | Intermediate-store read enable |
| im_rd_addr_o | output | 12 | Intermediate-store read address |
| im_wr_en_o | output | 1 | Intermediate-store write enable |
| im_wr_addr_o | output | 11 | Intermediate-store write address |
| tag_o | output | 8 | Delayed job descriptor |

## Verification
The embedded assertions watch the local invariants on every cycle: the state is frozen under stall, a wrap lasts one cycle, a skipped position ends after LH, positions stay inside the line bound, chrominance stays off the finest level, and memory enables stay low during wraps and stalls. Some properties involve whole-line and whole-group sequences, and only the bench scenarios can show them: the 15-entry level order, the placement of U and V jobs after each luminance job, the per-level position counts for several widths, the alternating intermediate read line, and the tag delay. The bench checks these against a model driven by random stall and skip patterns.

// File: rtl/subseq_pkg.sv
package subseq_pkg;
  localparam int unsigned COMP_W = 2;
  localparam int unsigned LVL_W  = 2;
  localparam int unsigned BAND_W = 2;
  localparam int unsigned SLOTS  = 15;

  localparam logic [1:0] BAND_LL = 2'd0;
  localparam logic [1:0] BAND_LH = 2'd1;
  localparam logic [1:0] BAND_HL = 2'd2;
  localparam logic [1:0] BAND_HH = 2'd3;

  localparam logic [1:0] COMP_Y = 2'd0;
  localparam logic [1:0] COMP_U = 2'd1;
  localparam logic [1:0] COMP_V = 2'd2;

  // slot 0 is the coarse level; two subtrees of 7 follow, each 1,{2,3,3},{2,3,3}
  function automatic logic [1:0] slot_level(input logic [3:0] slot);
    int unsigned t, u;
    if (slot == 4'd0) return 2'd0;
    t = (int'(slot) - 1) % 7;
    if (t == 0) return 2'd1;
    u = (t - 1) % 3;
    return (u == 0) ? 2'd2 : 2'd3;
  endfunction
endpackage

// File: rtl/subseq_order.sv
module subseq_order
  import subseq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             job_done_i,
  output logic [COMP_W-1:0] comp_o,
  output logic [LVL_W-1:0]  level_o,
  output logic             rd_line_o
);
  localparam int unsigned PAR_N = 12;

  logic [3:0]        slot_q;
  logic [1:0]        sub_q;
  logic [PAR_N-1:0]  par_q;
  logic [3:0]        idx;
  logic [LVL_W-1:0]  lvl;
  logic              next_slot;

  assign lvl       = slot_level(slot_q);
  assign idx       = {sub_q, lvl};
  assign next_slot = (sub_q == COMP_V) || (sub_q == COMP_Y && lvl == 2'd3);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_q <= '0;
      sub_q  <= COMP_Y;
      par_q  <= '0;
    end else if (job_done_i) begin
      par_q[idx] <= ~par_q[idx];
      if (next_slot) begin
        sub_q  <= COMP_Y;
        slot_q <= (slot_q == 4'(SLOTS - 1)) ? 4'd0 : slot_q + 4'd1;
      end else begin
        sub_q <= sub_q + 2'd1;
      end
    end
  end

  assign comp_o    = sub_q;
  assign level_o   = lvl;
  assign rd_line_o = par_q[idx];

  assert_chroma_depth_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sub_q != COMP_Y) |-> (lvl <= 2'd2));
  assert_slot_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_q < 4'(SLOTS));
  assert_order_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !job_done_i |=> ($stable(slot_q) && $stable(sub_q)));
endmodule

// File: rtl/subseq_line.sv
module subseq_line
  import subseq_pkg::*;
#(
  parameter int unsigned POS_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  input  logic             skip_i,
  input  logic [POS_W-1:0] last_pos_i,
  output logic [POS_W-1:0] pos_o,
  output logic [BAND_W-1:0] band_o,
  output logic             wrap_o,
  output logic             pos_end_o,
  output logic             job_done_o
);
  logic [POS_W-1:0]  pos_q;
  logic [BAND_W-1:0] band_q;
  logic              wrap_q, skip_q;

  assign pos_end_o  = !wrap_q && ((band_q == BAND_HH) || (band_q == BAND_LH && skip_q));
  assign job_done_o = adv_i && wrap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q  <= '0;
      band_q <= BAND_LL;
      wrap_q <= 1'b0;
      skip_q <= 1'b0;
    end else if (adv_i) begin
      if (wrap_q) begin
        wrap_q <= 1'b0;
      end else if (pos_end_o) begin
        band_q <= BAND_LL;
        if (pos_q == last_pos_i) begin
          pos_q  <= '0;
          wrap_q <= 1'b1;
        end else begin
          pos_q <= pos_q + 1'b1;
        end
      end else begin
        if (band_q == BAND_LL) skip_q <= skip_i;
        band_q <= band_q + 2'd1;
      end
    end
  end

  assign pos_o  = pos_q;
  assign band_o = band_q;
  assign wrap_o = wrap_q;

  assert_skip_short_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !wrap_q && band_q == BAND_LH && skip_q) |=> (band_q == BAND_LL));
  assert_wrap_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && wrap_q) |=> !wrap_q);
  assert_line_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> ($stable(pos_q) && $stable(band_q) && $stable(wrap_q)));
  assert_pos_bound_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pos_q <= last_pos_i);
endmodule

// File: rtl/subseq_tag_pipe.sv
module subseq_tag_pipe #(
  parameter int unsigned TAG_W = 8,
  parameter int unsigned DEPTH = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  input  logic [TAG_W-1:0] tag_i,
  output logic [TAG_W-1:0] tag_o
);
  if (DEPTH == 0) begin : g_bypass
    assign tag_o = tag_i;
  end else begin : g_pipe
    logic [TAG_W-1:0] stage_q [DEPTH];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int i = 0; i < int'(DEPTH); i++) stage_q[i] <= '0;
      end else if (adv_i) begin
        stage_q[0] <= tag_i;
        for (int i = 1; i < int'(DEPTH); i++) stage_q[i] <= stage_q[i-1];
      end
    end

    assign tag_o = stage_q[DEPTH-1];

    assert_tag_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !adv_i |=> $stable(tag_o));
  end
endmodule

// File: rtl/subband_seq.sv
module subband_seq
  import subseq_pkg::*;
#(
  parameter int unsigned MAX_WIDTH  = 256,
  parameter int unsigned PIPE_DEPTH = 3,
  localparam int unsigned WIDTH_W   = $clog2(MAX_WIDTH) + 1,
  localparam int unsigned POS_W     = $clog2(MAX_WIDTH / 2),
  localparam int unsigned ADDR_W    = COMP_W + LVL_W + POS_W,
  localparam int unsigned RD_ADDR_W = ADDR_W + 1,
  localparam int unsigned TAG_W     = 2 + COMP_W + LVL_W + BAND_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 stall_i,
  input  logic                 skip_i,
  input  logic [WIDTH_W-1:0]   width_i,
  output logic                 valid_o,
  output logic [COMP_W-1:0]    comp_o,
  output logic [LVL_W-1:0]     level_o,
  output logic [BAND_W-1:0]    band_o,
  output logic [POS_W-1:0]     pos_o,
  output logic                 wrap_o,
  output logic                 ld_en_o,
  output logic [ADDR_W-1:0]    ld_addr_o,
  output logic                 im_rd_en_o,
  output logic [RD_ADDR_W-1:0] im_rd_addr_o,
  output logic                 im_wr_en_o,
  output logic [ADDR_W-1:0]    im_wr_addr_o,
  output logic [TAG_W-1:0]     tag_o
);
  logic              run_q, adv;
  logic              job_done, pos_end, rd_line;
  logic [COMP_W-1:0] comp;
  logic [LVL_W-1:0]  level, level_dn, top_lvl;
  logic [BAND_W-1:0] band;
  logic [POS_W-1:0]  pos, last_pos;
  logic              wrap;
  logic [WIDTH_W-1:0] n_pos;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_q <= 1'b0;
    else         run_q <= 1'b1;
  end

  assign adv = run_q && !stall_i;

  subseq_order u_order (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .job_done_i (job_done),
    .comp_o     (comp),
    .level_o    (level),
    .rd_line_o  (rd_line)
  );

  // band width halves per coarser level: width >> (4 - level)
  always_comb begin
    n_pos    = width_i >> (3'd4 - {1'b0, level});
    last_pos = POS_W'(n_pos - 1'b1);
  end

  subseq_line #(.POS_W(POS_W)) u_line (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .adv_i      (adv),
    .skip_i     (skip_i),
    .last_pos_i (last_pos),
    .pos_o      (pos),
    .band_o     (band),
    .wrap_o     (wrap),
    .pos_end_o  (pos_end),
    .job_done_o (job_done)
  );

  assign top_lvl  = (comp == COMP_Y) ? 2'd3 : 2'd2;
  assign level_dn = level - 2'd1;

  assign valid_o      = adv;
  assign comp_o       = comp;
  assign level_o      = level;
  assign band_o       = band;
  assign pos_o        = pos;
  assign wrap_o       = wrap;
  assign ld_en_o      = adv && !wrap;
  assign ld_addr_o    = {comp, level, pos};
  assign im_rd_en_o   = adv && !wrap && band == BAND_LL && level != 2'd0;
  assign im_rd_addr_o = {comp, level_dn, rd_line, pos};
  assign im_wr_en_o   = adv && pos_end && level < top_lvl;
  assign im_wr_addr_o = {comp, level, pos};

  subseq_tag_pipe #(.TAG_W(TAG_W), .DEPTH(PIPE_DEPTH)) u_tag (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .adv_i  (adv),
    .tag_i  ({1'b1, wrap, comp, level, band}),
    .tag_o  (tag_o)
  );

  assert_wrap_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_o |-> !(ld_en_o || im_rd_en_o || im_wr_en_o));
  assert_stall_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_i |-> !(valid_o || ld_en_o || im_rd_en_o || im_wr_en_o));
  assert_top_nowrite_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    im_wr_en_o |-> !(level_o == 2'd3 || (comp_o != COMP_Y && level_o == 2'd2)));
  assert_rd_coarse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    im_rd_en_o |-> (band_o == BAND_LL && level_o != 2'd0));
endmodule

// File: tb/subband_seq_bench.sv
module subband_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        stall = 1'b0;
  logic        skip = 1'b0;
  logic [8:0]  width = 9'd16;
  logic        valid_o, wrap_o, ld_en_o, im_rd_en_o, im_wr_en_o;
  logic [1:0]  comp_o, level_o, band_o;
  logic [6:0]  pos_o;
  logic [10:0] ld_addr_o, im_wr_addr_o;
  logic [11:0] im_rd_addr_o;
  logic [7:0]  tag_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  subband_seq u_subband_seq (
    .clk_i(clk), .rst_ni(rst_n), .stall_i(stall), .skip_i(skip), .width_i(width),
    .valid_o(valid_o), .comp_o(comp_o), .level_o(level_o), .band_o(band_o),
    .pos_o(pos_o), .wrap_o(wrap_o), .ld_en_o(ld_en_o), .ld_addr_o(ld_addr_o),
    .im_rd_en_o(im_rd_en_o), .im_rd_addr_o(im_rd_addr_o), .im_wr_en_o(im_wr_en_o),
    .im_wr_addr_o(im_wr_addr_o), .tag_o(tag_o)
  );

  int lvl_seq [15] = '{0,1,2,3,3,2,3,3,1,2,3,3,2,3,3};
  int m_slot, m_sub, m_pos, m_band;
  bit m_wrap, m_skipq, m_run;
  bit m_par [3][4];
  int hist [3];

  function automatic int m_level();
    return lvl_seq[m_slot];
  endfunction

  function automatic int m_npos();
    return int'(width) >> (4 - m_level());
  endfunction

  task automatic check(string req, string name, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h t=%0t", req, name, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_slot = 0; m_sub = 0; m_pos = 0; m_band = 0;
    m_wrap = 0; m_skipq = 0; m_run = 0;
    for (int c = 0; c < 3; c++) for (int l = 0; l < 4; l++) m_par[c][l] = 0;
    for (int i = 0; i < 3; i++) hist[i] = 0;
  endtask

  task automatic check_all();
    bit act;
    bit pend;
    int lvl, top;
    act  = m_run && !stall;
    lvl  = m_level();
    top  = (m_sub == 0) ? 3 : 2;
    pend = !m_wrap && (m_band == 3 || (m_band == 1 && m_skipq));
    check("R8", "valid", valid_o, act);
    check("R3", "comp", comp_o, m_sub);
    check("R2", "level", level_o, lvl);
    check("R4", "band", band_o, m_band);
    check("R6", "pos", pos_o, m_pos);
    check("R7", "wrap", wrap_o, m_wrap);
    check("R11", "ld_en", ld_en_o, act && !m_wrap);
    if (act && !m_wrap) check("R11", "ld_addr", ld_addr_o, (m_sub << 9) | (lvl << 7) | m_pos);
    check("R9", "rd_en", im_rd_en_o, act && !m_wrap && m_band == 0 && lvl > 0);
    if (im_rd_en_o)
      check("R9", "rd_addr", im_rd_addr_o,
            (m_sub << 10) | ((lvl - 1) << 8) | (int'(m_par[m_sub][lvl]) << 7) | m_pos);
    check("R10", "wr_en", im_wr_en_o, act && pend && lvl < top);
    if (im_wr_en_o) check("R10", "wr_addr", im_wr_addr_o, (m_sub << 9) | (lvl << 7) | m_pos);
    check("R12", "tag", tag_o, hist[2]);
  endtask

  task automatic model_step();
    if (m_run && !stall) begin
      hist[2] = hist[1];
      hist[1] = hist[0];
      hist[0] = 128 | (int'(m_wrap) << 6) | (m_sub << 4) | (m_level() << 2) | m_band;
      if (m_wrap) begin
        m_wrap = 0;
        m_par[m_sub][m_level()] = !m_par[m_sub][m_level()];
        if (m_sub == 2 || (m_sub == 0 && m_level() == 3)) begin
          m_sub = 0;
          m_slot = (m_slot + 1) % 15;
        end else m_sub++;
      end else if (m_band == 3 || (m_band == 1 && m_skipq)) begin
        m_band = 0;
        if (m_pos == m_npos() - 1) begin m_pos = 0; m_wrap = 1; end
        else m_pos++;
      end else begin
        if (m_band == 0) m_skipq = skip;
        m_band++;
      end
    end
    m_run = 1;
  endtask

  task automatic do_reset(input logic [8:0] w);
    rst_n = 1'b0; stall = 1'b0; skip = 1'b0; width = w;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", "rst_valid", valid_o, 0);
    check("R1", "rst_tag", tag_o, 0);
    check("R1", "rst_pos", pos_o, 0);
    check("R1", "rst_band", band_o, 0);
    check("R1", "rst_comp", comp_o, 0);
    check("R1", "rst_level", level_o, 0);
    model_reset();
    rst_n = 1'b1;
  endtask

  // stall_pct / skip_pct in percent
  task automatic run_phase(int cycles, int stall_pct, int skip_pct);
    for (int n = 0; n < cycles; n++) begin
      stall = ($urandom % 100) < stall_pct;
      skip  = ($urandom % 100) < skip_pct;
      #1;
      check_all();
      model_step();
      @(negedge clk);
    end
  endtask

  initial begin
    void'($urandom(32'd7341));
    // R2 R3 R4 R6 R7: full groups, no stall, no skip
    do_reset(9'd16);
    run_phase(1200, 0, 0);
    // R5 R8 R9 R10 R12: random stall and skip
    do_reset(9'd32);
    run_phase(4000, 30, 50);
    // R5: skip always on
    do_reset(9'd48);
    run_phase(1500, 10, 100);
    // R6: widest line
    do_reset(9'd256);
    run_phase(10000, 10, 25);
    // R1: reset mid-run
    do_reset(9'd16);
    run_phase(50, 0, 0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule